// File: doc/BRIEF.md
# Tri-State Phase Detector with Lock Monitor

This block is the digital core of a frequency synthesizer's phase comparator. It takes one-cycle edge pulses from the divided reference path and the divided oscillator path. It raises a pump-up enable when the reference edge leads and a pump-down enable when the oscillator edge leads. Once both edges of a comparison have been seen, both enables are released on the following clock. When only one enable is high, the analog pump either sources or sinks current. When neither is high, the pump output floats.

Each comparison is timed in system clock cycles. The error is the number of cycles in which exactly one enable was high. A comparison counts as tight when this error is no more than `LOCK_WIN_PS / CLK_PS` cycles, which is 25 cycles with the default parameters. The lock flag rises once `LOCK_RUNS` tight comparisons (default 7) have occurred in a row. One loose comparison clears the flag. A pump-off control silences the detector and holds the lock flag low.

The pump current selection is a 2-bit code. It is taken from two select inputs when a write-complete strobe arrives. The new code reaches the pump only while no enable is active, so that a magnitude change never falls inside a pump pulse.

Top module: `pfd_lock_top`

## Requirements
- R1: A reference edge with no oscillator edge pending sets `up_o` high and leaves `dn_o` low, starting the clock after the pulse is sampled. An oscillator edge with no reference edge pending does the opposite.
- R2: Once both enables are high, both return low on the next clock, unless new edge pulses arrive in that same cycle.
- R3: `active_o` is high exactly when `up_o` or `dn_o` is high.
- R4: `lock_o` rises after 7 consecutive comparisons whose error is at most 25 cycles. Six such comparisons are not enough.
- R5: A comparison whose error exceeds 25 cycles (an error of 26 or more) clears the run count, and `lock_o` falls on the clock after that comparison completes. An error of exactly 25 still counts as tight.
- R6: While `pump_off_i` is high, from the next clock onward, `up_o`, `dn_o` and `lock_o` are low and edge pulses have no effect. The run count restarts at zero.
- R7: `cur_code_o` is `{isel_hi_i, isel_lo_i}` as captured at a `cfg_load_i` pulse. Code 0 means 50 µA, 1 means 100 µA (`isel_lo_i` alone), 2 means 150 µA (`isel_hi_i` alone) and 3 means 200 µA. After reset the code is 0.
- R8: A captured code is not applied while `active_o` is high. It is applied on the first clock at which the pump is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_edge_i | input | 1 | One-cycle pulse marking a divided reference edge |
| vco_edge_i | input | 1 | One-cycle pulse marking a divided oscillator edge |
| pump_off_i | input | 1 | Forces the pump off and disables lock detection |
| isel_lo_i | input | 1 | Current select, low weight |
| isel_hi_i | input | 1 | Current select, high weight |
| cfg_load_i | input | 1 | Write-complete strobe that captures the current selects |
| up_o | output | 1 | Pump source enable |
| dn_o | output | 1 | Pump sink enable |
| active_o | output | 1 | Pump is sourcing or sinking |
| cur_code_o | output | 2 | Pump magnitude code applied to the analog pump |
| lock_o | output | 1 | Phase lock indication |

## Verification
The bench places the lock window on its boundary: errors of 25 and 26 cycles separate a design that compares with the wrong inequality, which would lose lock or keep it one cycle of error too early. It runs six and then seven tight comparisons so that an off-by-one run counter shows up as early or late lock. It also follows a locked run with a single 30-cycle error, which would leave `lock_o` high in a design that only decrements the count. A current change is loaded in the middle of a pump pulse; a design without the idle gate would switch `cur_code_o` during the pulse. Comparisons made with the pump off must leave the enables and the lock flag low, and the lock run must then start again from zero.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef logic [1:0] cur_code_t;

  function automatic cur_code_t pack_code(input logic hi, input logic lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_edge_i,
  input  logic vco_edge_i,
  input  logic off_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q, both;

  assign both = up_q & dn_q;

  // both seen: release next clock, no dead zone beyond one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (off_i) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= (up_q & ~both) | ref_edge_i;
      dn_q <= (dn_q & ~both) | vco_edge_i;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/pfd_err_meter.sv
module pfd_err_meter #(
  parameter int unsigned THR = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic off_i,
  output logic done_o,
  output logic tight_o
);
  localparam int unsigned CW = $clog2(THR + 2);
  localparam logic [CW-1:0] SAT = CW'(THR + 1);
  localparam logic [CW-1:0] LIM = CW'(THR);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (off_i || done_o)          cnt_q <= '0;
    else if ((up_i ^ dn_i) && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o  = up_i & dn_i;
  assign tight_o = cnt_q <= LIM;
endmodule

// File: rtl/pfd_lock_cnt.sv
module pfd_lock_cnt #(
  parameter int unsigned RUNS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic tight_i,
  input  logic off_i,
  output logic lock_o
);
  localparam int unsigned LW = $clog2(RUNS + 1);
  localparam logic [LW-1:0] TOP = LW'(RUNS);

  logic [LW-1:0] run_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (off_i) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (done_i) begin
      if (!tight_i) begin
        run_q  <= '0;
        lock_q <= 1'b0;
      end else if (run_q >= TOP - 1'b1) begin
        run_q  <= TOP;
        lock_q <= 1'b1;
      end else begin
        run_q  <= run_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pfd_cur_sync.sv
module pfd_cur_sync
  import pfd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  cur_code_t new_i,
  input  logic      busy_i,
  output cur_code_t code_o
);
  cur_code_t pend_q, code_q;
  logic      pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      code_q   <= '0;
    end else begin
      if (load_i) begin
        pend_q   <= new_i;
        pend_v_q <= 1'b1;
      end else if (pend_v_q && !busy_i) begin
        pend_v_q <= 1'b0;
      end
      if (pend_v_q && !busy_i) code_q <= pend_q;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int unsigned CLK_PS      = 10000,
  parameter int unsigned LOCK_WIN_PS = 250000,
  parameter int unsigned LOCK_RUNS   = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_edge_i,
  input  logic       vco_edge_i,
  input  logic       pump_off_i,
  input  logic       isel_lo_i,
  input  logic       isel_hi_i,
  input  logic       cfg_load_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       active_o,
  output logic [1:0] cur_code_o,
  output logic       lock_o
);
  localparam int unsigned THR = LOCK_WIN_PS / CLK_PS;

  logic up, dn, done, tight;

  pfd_core u_core (
    .clk_i, .rst_ni, .ref_edge_i, .vco_edge_i,
    .off_i(pump_off_i), .up_o(up), .dn_o(dn)
  );

  pfd_err_meter #(.THR(THR)) u_meter (
    .clk_i, .rst_ni, .up_i(up), .dn_i(dn), .off_i(pump_off_i),
    .done_o(done), .tight_o(tight)
  );

  pfd_lock_cnt #(.RUNS(LOCK_RUNS)) u_lock (
    .clk_i, .rst_ni, .done_i(done), .tight_i(tight),
    .off_i(pump_off_i), .lock_o
  );

  pfd_cur_sync u_cur (
    .clk_i, .rst_ni, .load_i(cfg_load_i),
    .new_i(pack_code(isel_hi_i, isel_lo_i)),
    .busy_i(active_o), .code_o(cur_code_o)
  );

  assign up_o     = up;
  assign dn_o     = dn;
  assign active_o = up | dn;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_edge_i,
  input logic       vco_edge_i,
  input logic       pump_off_i,
  input logic       up_o,
  input logic       dn_o,
  input logic       active_o,
  input logic [1:0] cur_code_o,
  input logic       lock_o
);
  p_up_needs_ref_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o) |-> $past(ref_edge_i));

  p_dn_needs_vco_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_o) |-> $past(vco_edge_i));

  p_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o && !ref_edge_i && !vco_edge_i) |=> (!up_o && !dn_o));

  p_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == (up_o || dn_o));

  p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_off_i |=> (!up_o && !dn_o && !lock_o));

  p_code_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_code_o != $past(cur_code_o)) |-> !$past(active_o));
endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
  .clk_i, .rst_ni, .ref_edge_i, .vco_edge_i, .pump_off_i,
  .up_o, .dn_o, .active_o, .cur_code_o, .lock_o
);

// File: tb/sim_pfd_lock_top.sv
module sim_pfd_lock_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_e = 1'b0, vco_e = 1'b0, off = 1'b0;
  logic s_lo = 1'b0, s_hi = 1'b0, load = 1'b0;
  logic up, dn, act, lock;
  logic [1:0] code;

  int n_chk = 0, n_bad = 0;
  int run_m = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pfd_lock_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_e), .vco_edge_i(vco_e),
    .pump_off_i(off), .isel_lo_i(s_lo), .isel_hi_i(s_hi), .cfg_load_i(load),
    .up_o(up), .dn_o(dn), .active_o(act), .cur_code_o(code), .lock_o(lock)
  );

  task automatic check(string req, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  // scoreboard monitor: expected {lock, code}
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {29'd0, lock, code}, {29'd0, e});
    end
  end

  task automatic push(string t, logic [1:0] c);
    exp_q.push_back({run_m >= 7, c});
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic compare(bit ref_first, int d, string t, logic [1:0] c);
    @(negedge clk);
    if (d == 0) begin ref_e = 1'b1; vco_e = 1'b1; end
    else if (ref_first) ref_e = 1'b1;
    else vco_e = 1'b1;
    @(negedge clk);
    ref_e = 1'b0; vco_e = 1'b0;
    if (d >= 2) begin
      check("R1 up", {31'd0, up}, {31'd0, ref_first & ~off});
      check("R1 dn", {31'd0, dn}, {31'd0, ~ref_first & ~off});
      check("R3 active", {31'd0, act}, {31'd0, ~off});
    end
    if (d >= 1) begin
      repeat (d - 1) @(negedge clk);
      if (ref_first) vco_e = 1'b1; else ref_e = 1'b1;
      @(negedge clk);
      ref_e = 1'b0; vco_e = 1'b0;
    end
    repeat (3) @(negedge clk);
    check("R2 released", {30'd0, up, dn}, 32'd0);
    if (off) run_m = 0;
    else if (d <= 25) run_m = (run_m < 7) ? run_m + 1 : 7;
    else run_m = 0;
    push(t, c);
  endtask

  task automatic load_cur(logic hi, logic lo);
    @(negedge clk);
    s_hi = hi; s_lo = lo; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    repeat (2) @(negedge clk);
    push("R7 code", {hi, lo});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset", {28'd0, up, dn, act, lock}, 32'd0);
    check("R7 reset code", {30'd0, code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: six tight comparisons, no lock
    for (int i = 0; i < 6; i++) compare(i[0], 3 + i, "R4 pre-lock", 2'd0);
    compare(1'b1, 25, "R4 seventh locks, R5 25 tight", 2'd0);
    compare(1'b0, 0, "R4 held", 2'd0);
    // R5: loose comparison drops lock
    compare(1'b1, 30, "R5 loose drops lock", 2'd0);
    for (int i = 0; i < 6; i++) compare(1'b0, 1, "R4 rebuild", 2'd0);
    compare(1'b1, 26, "R5 26 is loose", 2'd0);
    for (int i = 0; i < 7; i++) compare(1'b1, 2, "R4 relock", 2'd0);

    // R6: pump off
    @(negedge clk); off = 1'b1;
    @(negedge clk);
    check("R6 lock low", {31'd0, lock}, 32'd0);
    compare(1'b1, 5, "R6 off ignored", 2'd0);
    compare(1'b0, 5, "R6 off ignored", 2'd0);
    @(negedge clk); off = 1'b0;
    for (int i = 0; i < 6; i++) compare(1'b1, 4, "R6 restart from zero", 2'd0);
    compare(1'b1, 4, "R6 relock after restart", 2'd0);

    // R7: all codes
    load_cur(1'b0, 1'b1);
    load_cur(1'b1, 1'b0);
    load_cur(1'b1, 1'b1);
    load_cur(1'b0, 1'b0);

    // R8: load during an active pulse
    @(negedge clk); ref_e = 1'b1;
    @(negedge clk); ref_e = 1'b0; s_hi = 1'b1; s_lo = 1'b0; load = 1'b1;
    @(negedge clk); load = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 held while active", {30'd0, code}, 32'd0);
    vco_e = 1'b1;
    @(negedge clk); vco_e = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 applied when idle", {30'd0, code}, 32'd2);

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule